// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the access addresses for a four-beat burst in a synchronous burst memory. An address strobe captures a start address and a chip-enable qualifier. An advance input then steps a 2-bit beat counter. The two least-significant bits of the output address follow that counter in one of two orders. The upper address bits keep the captured value until the next strobe.

There are two load strobes: a processor-side strobe and a controller-side strobe. The burst order is chosen by a static mode pin. That pin acts combinationally on the output address and is never registered. A strobe always restarts the burst. A strobe taken while the chip enable is low leaves the generator idle, and it then ignores advance until a qualified load arrives.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_ni` is low, `addr_o`, `beat_o` and `active_o` are all zero.
- R2: A rising clock edge with `ld_pri_i` or `ld_sec_i` high and `ce_i` high loads a burst. After that edge, `addr_o` equals the `addr_i` that was sampled, `beat_o` is 0 and `active_o` is 1.
- R3: With no strobe and `adv_i` low, `beat_o` and `addr_o` hold their values across a clock edge.
- R4: With `interleave_i`=0 (linear), `addr_o[1:0]` = (start[1:0] + `beat_o`) mod 4. A start of 1 gives 1,2,3,0.
- R5: With `interleave_i`=1, `addr_o[1:0]` = start[1:0] XOR `beat_o`. A start of 1 gives 1,0,3,2.
- R6: `interleave_i` acts without a clock. Changing it changes `addr_o` within the same cycle.
- R7: If both strobes are high in the same cycle, the result is a single processor-side load: the `addr_i` of that edge is loaded, and `beat_o` is 0.
- R8: A strobe during a burst restarts it at beat 0. This holds even when `adv_i` is high on the same edge.
- R9: A strobe with `ce_i` low leaves `active_o`=0 and `beat_o`=0. `adv_i` then has no effect on `beat_o` or `addr_o` until a qualified load.
- R10: While a burst is active, `adv_i` at beat 3 wraps `beat_o` to 0, which brings back the start address.
- R11: Address bits above bit 1 change only on a strobe edge or on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_pri_i | input | 1 | Processor-side address strobe (wins over the controller-side strobe) |
| ld_sec_i | input | 1 | Controller-side address strobe |
| ce_i | input | 1 | Chip-enable qualifier, sampled with a strobe |
| adv_i | input | 1 | Advance to the next beat |
| interleave_i | input | 1 | Burst order: 0 linear, 1 interleaved; not clocked |
| addr_i | input | ADDR_W | Start address |
| addr_o | output | ADDR_W | Current access address |
| beat_o | output | 2 | Beat index within the burst |
| active_o | output | 1 | A qualified burst is in progress |

## Verification
The bench first walks a linear burst from an odd start. It continues past beat 3, which catches a counter that saturates instead of wrapping, or that carries into bit 2. It then runs an interleaved burst, which shows whether XOR was replaced by addition. It also fires strobes in the middle of a burst with advance held high: a design that lets advance win over the load would show beat 1 where beat 0 is expected. An unqualified load followed by repeated advances exposes a counter that ignores the chip enable. The mode pin is toggled between clock edges, which shows whether it was wrongly registered.

// File: rtl/bag_pkg.sv
package bag_pkg;
  localparam int BEAT_W = 2;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  function automatic logic [BEAT_W-1:0] burst_low(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] beat,
    input order_e            ord
  );
    if (ord == ORD_INTERLEAVE) return start ^ beat;
    else                       return start + beat;
  endfunction
endpackage

// File: rtl/bag_load_ctrl.sv
module bag_load_ctrl #(
  parameter int ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_pri_i,
  input  logic              ld_sec_i,
  input  logic              ce_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              load_o,
  output logic [ADDR_W-1:0] base_o,
  output logic              active_o
);
  logic pri_sel;

  // processor-side strobe takes precedence; both paths load the same bus
  assign pri_sel = ld_pri_i;
  assign load_o  = pri_sel | ld_sec_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o   <= '0;
      active_o <= 1'b0;
    end else if (load_o) begin
      base_o   <= addr_i;
      active_o <= ce_i;
    end
  end

  // R2
  load_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && ce_i) |=> (active_o && base_o == $past(addr_i)));

  // R9
  no_ce_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && !ce_i) |=> !active_o);

  // R11
  base_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_o |=> $stable(base_o));
endmodule

// File: rtl/bag_beat_cnt.sv
module bag_beat_cnt
  import bag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              en_i,
  output logic [BEAT_W-1:0] beat_o
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              beat_o <= '0;
    else if (load_i)          beat_o <= '0;
    else if (en_i && adv_i)   beat_o <= beat_o + 1'b1;
  end

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> $stable(beat_o));

  // R8
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (beat_o == '0));

  // R9
  idle_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !en_i) |=> $stable(beat_o));

  // R10
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && en_i && adv_i && beat_o == LAST_BEAT) |=> (beat_o == '0));
endmodule

// File: rtl/bag_order.sv
module bag_order
  import bag_pkg::*;
(
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  order_e            ord_i,
  output logic [BEAT_W-1:0] low_o
);
  assign low_o = burst_low(start_i, beat_i, ord_i);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_pri_i,
  input  logic              ld_sec_i,
  input  logic              ce_i,
  input  logic              adv_i,
  input  logic              interleave_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        beat_o,
  output logic              active_o
);
  logic              load;
  logic [ADDR_W-1:0] base;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] low;
  order_e            ord;

  // mode pin is static and deliberately not registered
  assign ord = order_e'(interleave_i);

  bag_load_ctrl #(.ADDR_W(ADDR_W)) u_load (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_pri_i (ld_pri_i),
    .ld_sec_i (ld_sec_i),
    .ce_i     (ce_i),
    .addr_i   (addr_i),
    .load_o   (load),
    .base_o   (base),
    .active_o (active_o)
  );

  bag_beat_cnt u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .adv_i  (adv_i),
    .en_i   (active_o),
    .beat_o (beat)
  );

  bag_order u_ord (
    .start_i (base[BEAT_W-1:0]),
    .beat_i  (beat),
    .ord_i   (ord),
    .low_o   (low)
  );

  assign addr_o = {base[ADDR_W-1:BEAT_W], low};
  assign beat_o = beat;

  // R11
  upper_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_pri_i || ld_sec_i) |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

  // R2
  first_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_pri_i && ce_i) |=> (addr_o == $past(addr_i) && beat_o == 2'd0));

  // R9
  idle_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> (beat_o == 2'd0));
endmodule

// File: tb/burst_addr_gen_tb.sv
`timescale 1ns/1ps
module burst_addr_gen_tb;
  localparam int AW = 8;
  localparam int NV = 19;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ld_pri_i = 1'b0, ld_sec_i = 1'b0, ce_i = 1'b0, adv_i = 1'b0;
  logic          interleave_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;
  logic [1:0]    beat_o;
  logic          active_o;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk_i = ~clk_i;

  burst_addr_gen #(.ADDR_W(AW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_pri_i(ld_pri_i), .ld_sec_i(ld_sec_i),
    .ce_i(ce_i), .adv_i(adv_i), .interleave_i(interleave_i), .addr_i(addr_i),
    .addr_o(addr_o), .beat_o(beat_o), .active_o(active_o)
  );

  // {pri,sec,ce,adv,mode, addr_i, exp_addr, exp_beat, exp_active}
  localparam logic [23:0] VEC [0:NV-1] = '{
    {5'b10100, 8'h45, 8'h45, 2'd0, 1'b1}, // R2 pri load, linear
    {5'b00010, 8'h00, 8'h46, 2'd1, 1'b1}, // R4
    {5'b00000, 8'h00, 8'h46, 2'd1, 1'b1}, // R3 hold
    {5'b00010, 8'h00, 8'h47, 2'd2, 1'b1}, // R4
    {5'b00010, 8'h00, 8'h44, 2'd3, 1'b1}, // R4 low wraps, R11 upper fixed
    {5'b00010, 8'h00, 8'h45, 2'd0, 1'b1}, // R10 beat wrap
    {5'b01101, 8'h9A, 8'h9A, 2'd0, 1'b1}, // R2 sec load, interleaved
    {5'b00011, 8'h00, 8'h9B, 2'd1, 1'b1}, // R5
    {5'b00011, 8'h00, 8'h98, 2'd2, 1'b1}, // R5
    {5'b00011, 8'h00, 8'h99, 2'd3, 1'b1}, // R5
    {5'b10111, 8'h33, 8'h33, 2'd0, 1'b1}, // R8 restart with adv high
    {5'b00011, 8'h00, 8'h32, 2'd1, 1'b1}, // R5
    {5'b11110, 8'h60, 8'h60, 2'd0, 1'b1}, // R7 both strobes
    {5'b00010, 8'h00, 8'h61, 2'd1, 1'b1}, // R4
    {5'b01000, 8'h7E, 8'h7E, 2'd0, 1'b0}, // R9 unqualified load
    {5'b00010, 8'h00, 8'h7E, 2'd0, 1'b0}, // R9 adv ignored
    {5'b00011, 8'h00, 8'h7E, 2'd0, 1'b0}, // R9 adv ignored
    {5'b10100, 8'h7E, 8'h7E, 2'd0, 1'b1}, // R2
    {5'b00010, 8'h00, 8'h7F, 2'd1, 1'b1}  // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic p, s, c, a, m, input logic [AW-1:0] ad);
    @(negedge clk_i);
    ld_pri_i = p; ld_sec_i = s; ce_i = c; adv_i = a; interleave_i = m; addr_i = ad;
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    #100000;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1;
    chk("R1 addr", addr_o, 0);
    chk("R1 beat", beat_o, 0);
    chk("R1 active", active_o, 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      v = VEC[i];
      drive(v[23], v[22], v[21], v[20], v[19], v[18:11]);
      chk($sformatf("R2 R3 R4 R5 R7 R8 R9 R10 vec %0d addr", i), addr_o, v[10:3]);
      chk($sformatf("R2 R3 R4 R5 R7 R8 R9 R10 vec %0d beat", i), beat_o, v[2:1]);
      chk($sformatf("R2 R9 vec %0d active", i), active_o, v[0]);
    end

    // R6: mode pin acts between edges
    drive(1, 0, 1, 0, 0, 8'h45);
    drive(0, 0, 0, 1, 0, 8'h00);
    @(negedge clk_i);
    adv_i = 1'b0;
    chk("R6 linear", addr_o, 8'h46);
    interleave_i = 1'b1;
    #1;
    chk("R6 switch to interleave", addr_o, 8'h44);
    interleave_i = 1'b0;
    #0.5;
    chk("R6 switch back", addr_o, 8'h46);

    // R11: adv over many cycles never touches upper bits
    for (int k = 0; k < 6; k++) begin
      drive(0, 0, 0, 1, k[0], 8'hFF);
      chk("R11 upper bits", addr_o[AW-1:2], 6'h11);
    end

    // R1: async reset mid-burst
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1 mid-burst addr", addr_o, 0);
    chk("R1 mid-burst beat", beat_o, 0);
    chk("R1 mid-burst active", active_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    drive(0, 0, 0, 1, 0, 8'h00);
    chk("R9 adv after reset", beat_o, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule